// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block shares one master clock among up to four pulse-width-modulated phase outputs of a multiphase buck controller. When enabled, it first runs a short detection window. During that window it reads two sense bits that report whether the phase-3 and phase-4 output pins are tied to ground. It then latches how many phases are active: two, three or four.

After the window closes, each master clock tick starts the next active phase in a fixed rotation. Each phase therefore switches at the master rate divided by the active count. A phase stays high until its own termination strobe arrives. Phases may overlap, and a phase that gets no strobe can stay high almost the whole period.

Dropping enable, or applying reset, clears everything. The next enable runs detection again.

Top module: `pwm_phase_seq`

## Requirements
- R1: With `rst` high, or at any clock edge where `en` is low, the block clears `pwm_o`, `detect_o` and `nphase_o` to zero from the next cycle on.
- R2: `detect_o` rises on the cycle after the first edge that samples `en` high. It stays high until the edge that counts the second `tick` of the window, then falls. While it is high, `pwm_o` is all zero and `nphase_o` reads 0, and ticks start no phase.
- R3: At the edge that closes the window, the count is taken from the sense bits, where a 1 means that pin is grounded. With `gnd3_i`=0 and `gnd4_i`=0 the count is 4. With `gnd3_i`=0 and `gnd4_i`=1 it is 3. With `gnd3_i`=1 it is 2, whatever `gnd4_i` reads. `nphase_o` shows the count as the binary value 2, 3 or 4 from the following cycle.
- R4: Once latched, the count holds while `en` stays high, whatever the sense bits do afterwards.
- R5: After the window, each `tick` sets one phase output at that edge. The first tick goes to phase 1 (`pwm_o[0]`). Later ticks go in order 1, 2, 3, 4, stopping at the highest active phase and wrapping back to phase 1.
- R6: Outputs of phases outside the active count (`pwm_o[3]` in three-phase mode, `pwm_o[3:2]` in two-phase mode) never go high.
- R7: A high phase output clears at the edge where its own bit of `term_i` is high. A strobe on any other bit has no effect on it.
- R8: When a phase's tick and its own strobe fall on the same edge, the output is set.
- R9: Phases that get no strobe stay high, so several outputs can be high at once, up to all four.
- R10: Taking `en` low and then high again reruns detection, so a different sense pattern gives a new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable; a low level clears the block |
| tick | input | 1 | One-cycle master clock tick |
| gnd3_i | input | 1 | 1 = phase-3 pin sensed grounded |
| gnd4_i | input | 1 | 1 = phase-4 pin sensed grounded |
| term_i | input | 4 | Per-phase termination strobes, bit i for phase i+1 |
| pwm_o | output | 4 | PWM logic outputs, bit i for phase i+1 |
| detect_o | output | 1 | High during the detection window |
| nphase_o | output | 3 | Latched active phase count (2, 3 or 4), 0 when not running |

## Verification
The bench sends strobes and ticks into the detection window. A design that counted window ticks wrongly, or let ticks through early, would show a high output or close the window on the wrong cycle.

It applies the case where only the phase-3 sense bit is set. A design that decoded the bits independently would report three phases and pulse phase 4.

It places a tick and the same phase's strobe on one edge to expose a clear-wins priority. It strobes the other phases while one is high to catch a shared clear. It checks that the rotation wraps after the third and second phases, and that the count holds when the sense bits change mid-run.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int PHASES = 4;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_DETECT,
        SEQ_RUN
    } seq_state_e;

    typedef logic [CNT_W-1:0] phase_cnt_t;

    typedef struct packed {
        logic gnd3;
        logic gnd4;
    } sense_t;

    // Phase-3 grounded forces two phases even if phase 4 reads live.
    function automatic phase_cnt_t count_from_sense(input sense_t s);
        phase_cnt_t c;
        if (s.gnd3)      c = phase_cnt_t'(2);
        else if (s.gnd4) c = phase_cnt_t'(3);
        else             c = phase_cnt_t'(4);
        return c;
    endfunction

endpackage

// File: rtl/mpwm_detect.sv
module mpwm_detect
    import mpwm_pkg::*;
#(
    parameter int DET_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  sense_t     sense,
    output seq_state_e state_o,
    output phase_cnt_t nphase_o
);
    localparam int TW = $clog2(DET_TICKS + 1);

    seq_state_e     state_q;
    phase_cnt_t     nphase_q;
    logic [TW-1:0]  tcnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q  <= SEQ_IDLE;
            tcnt_q   <= '0;
            nphase_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    state_q <= SEQ_DETECT;
                    tcnt_q  <= '0;
                end
                SEQ_DETECT: begin
                    if (tick) begin
                        if (tcnt_q == TW'(DET_TICKS - 1)) begin
                            state_q  <= SEQ_RUN;
                            nphase_q <= count_from_sense(sense);
                        end else begin
                            tcnt_q <= tcnt_q + TW'(1);
                        end
                    end
                end
                default: state_q <= SEQ_RUN;
            endcase
        end
    end

    assign state_o  = state_q;
    assign nphase_o = nphase_q;

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN && en) |=> $stable(nphase_q));

    // R3
    count_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN) |-> (nphase_q >= phase_cnt_t'(2) && nphase_q <= phase_cnt_t'(4)));

endmodule

// File: rtl/mpwm_rotor.sv
module mpwm_rotor
    import mpwm_pkg::*;
#(
    parameter int NPH = PHASES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           run,
    input  logic           tick,
    input  phase_cnt_t     nphase,
    output logic [NPH-1:0] set_o
);
    localparam int PW = $clog2(NPH);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] last;

    assign last = PW'(nphase - phase_cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ptr_q <= '0;
        end else if (tick) begin
            ptr_q <= (ptr_q == last) ? '0 : ptr_q + PW'(1);
        end
    end

    always_comb begin
        set_o = '0;
        if (run && en && tick) set_o[ptr_q] = 1'b1;
    end

    // R5
    one_set_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_o));

    // R6
    for (genvar i = 0; i < NPH; i++) begin : g_range
        set_range_chk: assert property (@(posedge clk) disable iff (rst)
            set_o[i] |-> (phase_cnt_t'(i) < nphase));
    end

endmodule

// File: rtl/mpwm_outstage.sv
module mpwm_outstage #(
    parameter int NPH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [NPH-1:0] set_i,
    input  logic [NPH-1:0] term_i,
    output logic [NPH-1:0] pwm_o
);
    logic [NPH-1:0] pwm_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPH; i++) begin
            if (rst || !en)     pwm_q[i] <= 1'b0;
            else if (set_i[i])  pwm_q[i] <= 1'b1;
            else if (term_i[i]) pwm_q[i] <= 1'b0;
        end
    end

    assign pwm_o = pwm_q;

    for (genvar i = 0; i < NPH; i++) begin : g_chk
        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (set_i[i] && en) |=> pwm_q[i]);
        // R7
        term_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (term_i[i] && !set_i[i]) |=> !pwm_q[i]);
        // R7
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!term_i[i] && !set_i[i] && en) |=> $stable(pwm_q[i]));
    end

endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
    import mpwm_pkg::*;
#(
    parameter int NPH       = PHASES,
    parameter int DET_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             gnd3_i,
    input  logic             gnd4_i,
    input  logic [NPH-1:0]   term_i,
    output logic [NPH-1:0]   pwm_o,
    output logic             detect_o,
    output logic [CNT_W-1:0] nphase_o
);
    seq_state_e     state;
    phase_cnt_t     nphase;
    sense_t         sense;
    logic [NPH-1:0] set_vec;
    logic           run;

    assign sense = '{gnd3: gnd3_i, gnd4: gnd4_i};
    assign run   = (state == SEQ_RUN);

    mpwm_detect #(.DET_TICKS(DET_TICKS)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .sense    (sense),
        .state_o  (state),
        .nphase_o (nphase)
    );

    mpwm_rotor #(.NPH(NPH)) u_rotor (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .run    (run),
        .tick   (tick),
        .nphase (nphase),
        .set_o  (set_vec)
    );

    mpwm_outstage #(.NPH(NPH)) u_out (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .set_i  (set_vec),
        .term_i (term_i),
        .pwm_o  (pwm_o)
    );

    assign detect_o = (state == SEQ_DETECT);
    assign nphase_o = nphase;

    // R1
    disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pwm_o == '0 && nphase_o == '0 && !detect_o));

    // R2
    window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        detect_o |-> (pwm_o == '0 && nphase_o == '0));

    // R6
    three_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (nphase_o == CNT_W'(3)) |-> !pwm_o[NPH-1]);

    // R6
    two_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (nphase_o == CNT_W'(2)) |-> (pwm_o[NPH-1:NPH-2] == '0));

endmodule

// File: tb/pwm_phase_seq_bench.sv
module pwm_phase_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       gnd3 = 1'b0;
    logic       gnd4 = 1'b0;
    logic [3:0] term = '0;
    logic [3:0] pwm;
    logic       detect;
    logic [2:0] nphase;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    pwm_phase_seq u_pwm_phase_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .gnd3_i   (gnd3),
        .gnd4_i   (gnd4),
        .term_i   (term),
        .pwm_o    (pwm),
        .detect_o (detect),
        .nphase_o (nphase)
    );

    // {tick, term[3:0], expected pwm[3:0]} in four-phase mode, rotation at phase 1
    localparam int NV = 14;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 4'b0000, 4'b0001},  // R5 first tick to phase 1
        {1'b0, 4'b0000, 4'b0001},  // R9 held without strobe
        {1'b1, 4'b0000, 4'b0011},  // R9 overlap
        {1'b1, 4'b0001, 4'b0110},  // R7 phase 1 ends
        {1'b1, 4'b0000, 4'b1110},  // R5 phase 4
        {1'b1, 4'b0001, 4'b1111},  // R8 set beats strobe, R9 all high
        {1'b0, 4'b1110, 4'b0001},  // R7
        {1'b0, 4'b0001, 4'b0000},  // R7
        {1'b1, 4'b0100, 4'b0010},  // R7 strobe on idle phase
        {1'b0, 4'b1101, 4'b0010},  // R7 foreign strobes ignored
        {1'b1, 4'b0010, 4'b0100},  // R5 R7
        {1'b1, 4'b0000, 4'b1100},  // R5
        {1'b0, 4'b1100, 4'b0000},  // R7
        {1'b1, 4'b0000, 4'b0001}   // R5 wrap to phase 1
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tk, input logic [3:0] tm);
        @(negedge clk);
        tick = tk;
        term = tm;
        @(posedge clk);
        #2;
    endtask

    task automatic bringup(input logic g3, input logic g4, input logic [2:0] expcnt);
        @(negedge clk);
        en = 1'b0; tick = 1'b0; term = '0;
        @(posedge clk); #2;
        chk("R1 pwm after disable", 8'(pwm), 8'h0);
        chk("R1 count after disable", 8'(nphase), 8'h0);
        @(negedge clk);
        en = 1'b1; gnd3 = g3; gnd4 = g4;
        @(posedge clk); #2;
        chk("R2 window opens", 8'(detect), 8'h1);
        chk("R2 count hidden", 8'(nphase), 8'h0);
        cyc(1'b1, 4'b1111);
        chk("R2 window after one tick", 8'(detect), 8'h1);
        chk("R2 quiet in window", 8'(pwm), 8'h0);
        cyc(1'b1, 4'b0000);
        chk("R2 window closes", 8'(detect), 8'h0);
        chk("R3 latched count", 8'(nphase), 8'(expcnt));
        chk("R2 no start in window", 8'(pwm), 8'h0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2;
        chk("R1 reset pwm", 8'(pwm), 8'h0);
        chk("R1 reset detect", 8'(detect), 8'h0);
        chk("R1 reset count", 8'(nphase), 8'h0);
        @(negedge clk);
        rst = 1'b0;

        bringup(1'b0, 1'b0, 3'd4);
        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k][8], VEC[k][7:4]);
            chk($sformatf("R5/R7/R8/R9 vector %0d", k), 8'(pwm), 8'(VEC[k][3:0]));
        end

        // three phases: tick plus all strobes leaves only the started phase high
        bringup(1'b0, 1'b1, 3'd3);
        cyc(1'b1, 4'b1111); chk("R5 three-phase p1", 8'(pwm), 8'b0001);
        cyc(1'b1, 4'b1111); chk("R5 three-phase p2", 8'(pwm), 8'b0010);
        cyc(1'b1, 4'b1111); chk("R6 three-phase p3", 8'(pwm), 8'b0100);
        cyc(1'b1, 4'b1111); chk("R6 three-phase wrap", 8'(pwm), 8'b0001);
        @(negedge clk); gnd4 = 1'b0; gnd3 = 1'b1;
        cyc(1'b0, 4'b0000); cyc(1'b0, 4'b0000);
        chk("R4 count held", 8'(nphase), 8'h3);

        // only phase-3 pin grounded still gives two phases
        bringup(1'b1, 1'b0, 3'd2);
        cyc(1'b1, 4'b1111); chk("R5 two-phase p1", 8'(pwm), 8'b0001);
        cyc(1'b1, 4'b1111); chk("R5 two-phase p2", 8'(pwm), 8'b0010);
        cyc(1'b1, 4'b1111); chk("R6 two-phase wrap", 8'(pwm), 8'b0001);
        cyc(1'b1, 4'b0000); cyc(1'b1, 4'b0000);
        chk("R6 two-phase upper low", 8'(pwm), 8'b0011);

        bringup(1'b1, 1'b1, 3'd2);
        bringup(1'b0, 1'b0, 3'd4);
        chk("R10 rerun detection", 8'(nphase), 8'h4);
        cyc(1'b1, 4'b0000); cyc(1'b1, 4'b0000);
        chk("R5 after rerun", 8'(pwm), 8'b0011);

        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        chk("R1 reset mid-run pwm", 8'(pwm), 8'h0);
        chk("R1 reset mid-run count", 8'(nphase), 8'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule